// File: doc/BRIEF.md
# Delayed Transaction Discard Timer

This block watches the single delayed-read entry of a PCI-to-PCI bridge. When the completion data for a delayed transaction has been fetched and stored in the bridge buffer, the block arms a counter. If the originating master comes back and retries the transaction before the counter runs out, the entry is kept and the timer stops. If the master never returns, the entry is dropped on expiry. The drop sets a sticky status flag and, when enabled, emits a one-cycle system-error pulse.

Software controls the block through a 16-bit bridge-control slice. One bit chooses a long or a short timeout. One bit gates the error pulse. One bit holds the discard status, which is cleared by writing 1 to it. One bit drives the secondary bus reset, which flushes the pending entry for as long as it is set. A few further bits are plain read/write storage. The fast back-to-back bit and the top nibble always read as zero.

Top module: `dt_discard_watchdog`

## Requirements
- R1: After reset, `cfg_rdata` reads 0000h and `entry_pending`, `entry_discard`, `serr_pulse` and `sec_bus_rst` are all 0.
- R2: A write to `cfg_rdata` bits 11, 9, 8, 6 and 5:0 stores the written value, and that value reads back. Bits 15:12 and bit 7 (fast back-to-back) always read 0. A write never sets bit 10.
- R3: With bit 9 (timeout select) at 0, `entry_discard` goes high exactly 2^LONG_EXP clock edges after the edge that samples `cpl_stored` high, provided no retry arrives.
- R4: With bit 9 at 1, the discard happens exactly 2^SHORT_EXP edges after the arming edge.
- R5: A `retry_match` sampled while the entry is pending and before expiry clears `entry_pending` at that edge. No discard follows.
- R6: A discard sets bit 10 (discard status) at the same edge. Writing 1 to bit 10 clears it. Writing 0 to bit 10 leaves it unchanged.
- R7: A write of 1 to bit 10 at the same edge as a new expiry leaves bit 10 set.
- R8: `serr_pulse` is high for exactly the cycle in which `entry_discard` is high, and only when bit 11 (error enable) is 1. With bit 11 at 0 it stays low.
- R9: Bit 6 drives `sec_bus_rst`. While it is set, the pending entry is flushed without a discard and `cpl_stored` is ignored. The other stored bits keep their values.
- R10: `entry_discard` is a single-cycle pulse, and `entry_pending` is 0 in the cycle it is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the control slice |
| cfg_wdata | input | 16 | Write data for the control slice |
| cfg_rdata | output | 16 | Current value of the control slice |
| cpl_stored | input | 1 | Completion data for the delayed transaction is now in the buffer |
| retry_match | input | 1 | The master has repeated the delayed transaction |
| entry_pending | output | 1 | A stored completion is waiting for its retry |
| entry_discard | output | 1 | One-cycle pulse: the entry was dropped on expiry |
| serr_pulse | output | 1 | One-cycle system-error pulse on a gated expiry |
| sec_bus_rst | output | 1 | Secondary bus reset, active high |

## Verification
The bench builds the block with LONG_EXP=8 and SHORT_EXP=4, so the two timeouts are 256 and 16 cycles. This puts the exact expiry edge in both select modes, retries right up to the last cycle before expiry, and the same-edge status clear within a short run. These values also leave room for many randomized arm/retry sequences. The checker measures each entry's age with its own counter. The counter is sized from the parameters, so the same check covers the default 2^15 and 2^10 windows without unrolling.

// File: rtl/dtw_pkg.sv
package dtw_pkg;
  localparam int REG_W      = 16;
  localparam int B_ERR_EN   = 11;
  localparam int B_STATUS   = 10;
  localparam int B_SEL      = 9;
  localparam int B_PRI_TMR  = 8;
  localparam int B_FAST_B2B = 7;
  localparam int B_SBR      = 6;
  localparam int MISC_W     = 6;
endpackage

// File: rtl/dtw_ctrl_reg.sv
module dtw_ctrl_reg
  import dtw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  input  logic             expire,
  output logic [REG_W-1:0] rdata,
  output logic             err_en,
  output logic             sel_short,
  output logic             sbr
);
  logic              err_en_q, err_en_d;
  logic              stat_q, stat_d;
  logic              sel_q, sel_d;
  logic              pri_q, pri_d;
  logic              sbr_q, sbr_d;
  logic [MISC_W-1:0] misc_q, misc_d;
  logic              unused_wbits;

  assign unused_wbits = ^{wdata[REG_W-1:B_ERR_EN+1], wdata[B_FAST_B2B]};

  always_comb begin
    err_en_d = err_en_q;
    sel_d    = sel_q;
    pri_d    = pri_q;
    sbr_d    = sbr_q;
    misc_d   = misc_q;
    if (we) begin
      err_en_d = wdata[B_ERR_EN];
      sel_d    = wdata[B_SEL];
      pri_d    = wdata[B_PRI_TMR];
      sbr_d    = wdata[B_SBR];
      misc_d   = wdata[MISC_W-1:0];
    end
    // a new expiry outranks a same-edge clear
    stat_d = (stat_q & ~(we & wdata[B_STATUS])) | expire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_en_q <= 1'b0;
      stat_q   <= 1'b0;
      sel_q    <= 1'b0;
      pri_q    <= 1'b0;
      sbr_q    <= 1'b0;
      misc_q   <= '0;
    end else begin
      err_en_q <= err_en_d;
      stat_q   <= stat_d;
      sel_q    <= sel_d;
      pri_q    <= pri_d;
      sbr_q    <= sbr_d;
      misc_q   <= misc_d;
    end
  end

  always_comb begin
    rdata             = '0;
    rdata[B_ERR_EN]   = err_en_q;
    rdata[B_STATUS]   = stat_q;
    rdata[B_SEL]      = sel_q;
    rdata[B_PRI_TMR]  = pri_q;
    rdata[B_SBR]      = sbr_q;
    rdata[MISC_W-1:0] = misc_q;
  end

  assign err_en    = err_en_q;
  assign sel_short = sel_q;
  assign sbr       = sbr_q;
endmodule

// File: rtl/dtw_timer.sv
module dtw_timer #(
  parameter int LONG_EXP  = 15,
  parameter int SHORT_EXP = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_short,
  input  logic flush,
  input  logic arm,
  input  logic retry,
  output logic pending,
  output logic expire_now
);
  localparam int CNT_W = LONG_EXP;
  localparam logic [CNT_W-1:0] LIM_LONG_M1  = CNT_W'((1 << LONG_EXP) - 1);
  localparam logic [CNT_W-1:0] LIM_SHORT_M1 = CNT_W'((1 << SHORT_EXP) - 1);

  logic             pend_q, pend_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic [CNT_W-1:0] lim_m1;

  assign lim_m1     = sel_short ? LIM_SHORT_M1 : LIM_LONG_M1;
  // >= keeps a mid-count switch to the short window from wrapping
  assign expire_now = pend_q && !flush && !arm && !retry && (cnt_q >= lim_m1);

  always_comb begin
    pend_d = pend_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b1;
    if (flush) begin
      pend_d = 1'b0;
      cnt_d  = '0;
    end else if (arm) begin
      pend_d = 1'b1;
      cnt_d  = '0;
    end else if (retry || expire_now) begin
      pend_d = 1'b0;
      cnt_d  = '0;
    end else if (pend_q) begin
      cnt_d  = cnt_q + 1'b1;
    end else begin
      cnt_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (cnt_en) begin
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
    end
  end

  assign pending = pend_q;
endmodule

// File: rtl/dtw_report.sv
module dtw_report (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic err_en,
  output logic discard,
  output logic serr
);
  logic discard_d, serr_d;

  always_comb begin
    discard_d = expire;
    serr_d    = expire & err_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      discard <= 1'b0;
      serr    <= 1'b0;
    end else begin
      discard <= discard_d;
      serr    <= serr_d;
    end
  end
endmodule

// File: rtl/dt_discard_watchdog.sv
module dt_discard_watchdog
  import dtw_pkg::*;
#(
  parameter int LONG_EXP  = 15,
  parameter int SHORT_EXP = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic             cpl_stored,
  input  logic             retry_match,
  output logic             entry_pending,
  output logic             entry_discard,
  output logic             serr_pulse,
  output logic             sec_bus_rst
);
  logic err_en, sel_short, sbr, expire;

  dtw_ctrl_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .wdata    (cfg_wdata),
    .expire   (expire),
    .rdata    (cfg_rdata),
    .err_en   (err_en),
    .sel_short(sel_short),
    .sbr      (sbr)
  );

  dtw_timer #(.LONG_EXP(LONG_EXP), .SHORT_EXP(SHORT_EXP)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_short (sel_short),
    .flush     (sbr),
    .arm       (cpl_stored),
    .retry     (retry_match),
    .pending   (entry_pending),
    .expire_now(expire)
  );

  dtw_report u_rpt (
    .clk    (clk),
    .rst_n  (rst_n),
    .expire (expire),
    .err_en (err_en),
    .discard(entry_discard),
    .serr   (serr_pulse)
  );

  assign sec_bus_rst = sbr;
endmodule

// File: rtl/dtw_chk.sv
module dtw_chk
  import dtw_pkg::*;
#(
  parameter int LONG_EXP  = 15,
  parameter int SHORT_EXP = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [REG_W-1:0] cfg_wdata,
  input logic [REG_W-1:0] cfg_rdata,
  input logic             cpl_stored,
  input logic             retry_match,
  input logic             entry_pending,
  input logic             entry_discard,
  input logic             serr_pulse,
  input logic             sec_bus_rst
);
  localparam int AGE_W = LONG_EXP + 2;
  localparam logic [AGE_W-1:0] AGE_MIN = AGE_W'((1 << SHORT_EXP) + 1);
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'((1 << LONG_EXP) + 1);

  logic [AGE_W-1:0] age_q;
  logic             unused_chk;
  assign unused_chk = ^{cfg_we, cfg_wdata};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= '0;
    else if (cpl_stored && !sec_bus_rst) age_q <= AGE_W'(1);
    else if (entry_pending) age_q <= age_q + 1'b1;
    else age_q <= '0;
  end

  // R8
  serr_with_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    serr_pulse |-> entry_discard);
  // R10
  discard_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_discard |=> !entry_discard);
  // R10
  discard_not_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_discard |-> !entry_pending);
  // R6
  discard_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_discard |-> cfg_rdata[B_STATUS]);
  // R9
  sbr_flushes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_bus_rst && $past(sec_bus_rst)) |-> (!entry_pending && !entry_discard));
  // R5
  retry_cancels_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retry_match && !cpl_stored) |=> (!entry_pending && !entry_discard));
  // R3
  discard_age_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_discard |-> (age_q >= AGE_MIN && age_q <= AGE_MAX));
  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[REG_W-1:B_ERR_EN+1] == '0) && !cfg_rdata[B_FAST_B2B]);
endmodule

bind dt_discard_watchdog dtw_chk #(.LONG_EXP(LONG_EXP), .SHORT_EXP(SHORT_EXP)) u_chk (.*);

// File: tb/tb_dt_discard_watchdog.sv
module tb_dt_discard_watchdog;
  localparam int LE = 8;
  localparam int SE = 4;
  localparam int LIM_L = 1 << LE;
  localparam int LIM_S = 1 << SE;
  localparam logic [15:0] RW_MASK = 16'h0B7F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        cpl_stored = 1'b0;
  logic        retry_match = 1'b0;
  logic        entry_pending, entry_discard, serr_pulse, sec_bus_rst;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] shadow = '0;

  always #4 clk = ~clk;

  dt_discard_watchdog #(.LONG_EXP(LE), .SHORT_EXP(SE)) dut (.*);

  function automatic logic [15:0] exp_read(logic [15:0] stored, logic stat);
    return (stored & RW_MASK & ~16'h0400) | (stat ? 16'h0400 : 16'h0000);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(logic [15:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    step();
    cfg_we = 1'b0;
    shadow = v & ~16'h0400;
  endtask

  task automatic arm();
    cpl_stored = 1'b1; step(); cpl_stored = 1'b0;
  endtask

  task automatic retry();
    retry_match = 1'b1; step(); retry_match = 1'b0;
  endtask

  // counts negedges after the arm negedge until discard is seen
  task automatic wait_discard(int maxc, output int n, output logic serr_seen);
    n = -1; serr_seen = 1'b0;
    for (int i = 1; i <= maxc; i++) begin
      step();
      if (entry_discard) begin n = i; serr_seen = serr_pulse; break; end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int n;
    logic s;
    logic [15:0] v;
    void'($urandom(32'd20240611));
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    chk("R1 rdata", cfg_rdata, 0);
    chk("R1 pending", entry_pending, 0);
    chk("R1 discard", entry_discard, 0);
    chk("R1 serr", serr_pulse, 0);
    chk("R1 sbr", sec_bus_rst, 0);

    // R2 directed all-ones then random readback
    wr(16'hFFFF);
    chk("R2 all ones", cfg_rdata, exp_read(16'hFFFF, 1'b0));
    chk("R9 sbr out", sec_bus_rst, 1);
    for (int k = 0; k < 20; k++) begin
      v = 16'($urandom);
      wr(v);
      chk("R2 random", cfg_rdata, exp_read(v, 1'b0));
    end
    wr(16'h0000);
    chk("R2 zero", cfg_rdata, 0);

    // R3 long timeout, error disabled
    wr(16'h0100);
    arm();
    chk("R3 pending", entry_pending, 1);
    wait_discard(LIM_L + 8, n, s);
    chk("R3 long expiry cycle", n, LIM_L);
    chk("R8 no serr when disabled", s, 0);
    chk("R6 status set", cfg_rdata[10], 1);
    chk("R10 pending cleared", entry_pending, 0);
    step();
    chk("R10 single pulse", entry_discard, 0);

    // R6 write 0 keeps, write 1 clears
    wr(shadow);
    chk("R6 write0 keeps", cfg_rdata[10], 1);
    wr(shadow | 16'h0400);
    chk("R6 w1c clears", cfg_rdata[10], 0);
    chk("R6 other bits", cfg_rdata, exp_read(16'h0100, 1'b0));

    // R4 short timeout with error enable
    wr(16'h0A00);
    arm();
    wait_discard(LIM_S + 8, n, s);
    chk("R4 short expiry cycle", n, LIM_S);
    chk("R8 serr with discard", s, 1);
    step();
    chk("R8 serr single", serr_pulse, 0);
    wr(shadow | 16'h0400);

    // R5 random retry points before expiry
    for (int k = 0; k < 12; k++) begin
      int d;
      d = int'($urandom_range(LIM_S - 2, 0));
      if (k == 0) d = LIM_S - 2;
      arm();
      repeat (d) step();
      retry();
      chk("R5 pending cleared", entry_pending, 0);
      wait_discard(LIM_S + 6, n, s);
      chk("R5 no discard", n, -1);
    end
    chk("R5 status untouched", cfg_rdata[10], 0);

    // R7 clear on the expiry edge
    arm();
    repeat (LIM_S - 1) step();
    chk("R7 still pending", entry_pending, 1);
    wr(shadow | 16'h0400);
    chk("R7 discard now", entry_discard, 1);
    chk("R7 status kept", cfg_rdata[10], 1);
    wr(shadow | 16'h0400);
    chk("R7 later clear", cfg_rdata[10], 0);

    // R9 secondary reset flushes
    arm();
    repeat (3) step();
    wr(shadow | 16'h0040);
    chk("R9 sbr asserted", sec_bus_rst, 1);
    step();
    chk("R9 flushed", entry_pending, 0);
    arm();
    chk("R9 arm ignored", entry_pending, 0);
    wait_discard(LIM_S + 6, n, s);
    chk("R9 no discard", n, -1);
    chk("R9 others kept", cfg_rdata, exp_read(16'h0A40, 1'b0));
    wr(shadow & ~16'h0040);
    chk("R9 sbr released", sec_bus_rst, 0);
    arm();
    wait_discard(LIM_S + 8, n, s);
    chk("R4 after release", n, LIM_S);
    wr(shadow | 16'h0400);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule